// File: doc/BRIEF.md
# Global Bypass Attribute Register with Request Decision

This block holds the global bypass attribute register of an address translation unit and turns it into a per-request verdict. Software reaches the register over a 32-bit register port with a shared address bus. A write only lands when its top bit (the update flag) is set. The flag is removed before the value is stored, because the update finishes in the same cycle.

A request port carries a valid strobe and a small request tag. One cycle after each strobe, the block returns one of three verdicts together with the tag:

- translate, when the translation enable input is high;
- abort, when the enable is low and the stored abort bit is set;
- bypass, when the enable is low and the abort bit is clear. The transaction then passes through untranslated, using its incoming attributes.

The translation walk and attribute overrides live elsewhere in the unit.

Top module: `gbp_attr_ctl`

## Requirements
- R1: After reset the register at byte offset 0x44 reads 0x0000_1000, and no verdict is valid.
- R2: A write to offset 0x44 whose data bit 31 is 0 leaves the stored value unchanged.
- R3: A write to offset 0x44 whose data bit 31 is 1 stores the data with bit 31 cleared, so a read never returns bit 31 set.
- R4: Reads of any offset other than 0x44 return 0, and writes to such offsets change nothing.
- R5: A request made with the translation enable high gets verdict code 0 (translate), whatever the register holds.
- R6: A request made with the enable low and stored bit 20 (abort) clear gets verdict code 1 (bypass).
- R7: A request made with the enable low and stored bit 20 set gets verdict code 2 (abort). Code 3 never appears.
- R8: The verdict valid output is high exactly in the cycle after a request strobe, and it returns that request's tag; back-to-back strobes give back-to-back verdicts.
- R9: A register write in the same cycle as a request does not affect that request; the request is judged with the value stored before the write.
- R10: The translation enable is sampled in the request cycle only; changing it afterwards does not alter that verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| xlate_en | input | 1 | Global translation enable |
| req_valid | input | 1 | Request strobe |
| req_id | input | 4 | Request tag |
| dec_valid | output | 1 | Verdict valid, one cycle after req_valid |
| dec_code | output | 2 | Verdict: 0 translate, 1 bypass, 2 abort |
| dec_id | output | 4 | Tag of the request the verdict belongs to |

## Verification
A register update and a request decision can fall in the same clock cycle. The bench provokes this by driving a write with the update flag and a request strobe, with the enable low, on the same edge. It does this once to set the abort bit and once to clear it. It judges the outcome by requiring the colliding request to carry the verdict implied by the previous register value, and the very next request to carry the verdict implied by the new value.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

  typedef enum logic [1:0] {
    DEC_XLATE  = 2'd0,
    DEC_BYPASS = 2'd1,
    DEC_ABORT  = 2'd2
  } dec_e;

  // Value stored after a write that reaches the register.
  function automatic logic [31:0] gbp_apply_write(
    input logic [31:0] cur,
    input logic [31:0] wdata,
    input int unsigned upd_bit
  );
    logic [31:0] nxt;
    nxt = cur;
    if (wdata[upd_bit]) begin
      nxt = wdata;
      nxt[upd_bit] = 1'b0;
    end
    return nxt;
  endfunction

  // Verdict for one request.
  function automatic dec_e gbp_decide(
    input logic en,
    input logic abort_flag
  );
    if (en)              return DEC_XLATE;
    else if (abort_flag) return DEC_ABORT;
    else                 return DEC_BYPASS;
  endfunction

endpackage

// File: rtl/gbp_regfile.sv
module gbp_regfile
  import gbp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h44,
  parameter int unsigned UPD_BIT = 31,
  parameter int unsigned ABT_BIT = 20,
  parameter logic [DATA_W-1:0] RST_VAL = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              abort_flag
);

  logic [DATA_W-1:0] attr_q;
  logic              reg_hit;
  logic              wr_accept;
  logic              wr_drop;

  assign reg_hit   = (addr == REG_OFS);
  assign wr_accept = wr_en && reg_hit && wdata[UPD_BIT];
  assign wr_drop   = wr_en && !(reg_hit && wdata[UPD_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         attr_q <= RST_VAL;
    else if (wr_accept) attr_q <= gbp_apply_write(attr_q, wdata, UPD_BIT);
  end

  assign rdata      = reg_hit ? attr_q : '0;
  assign abort_flag = attr_q[ABT_BIT];

  // R2/R4: a write that does not qualify leaves the register alone
  p_ignore_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> $stable(attr_q));

  // R3: an accepted write lands with the update flag removed
  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (attr_q[UPD_BIT] == 1'b0) &&
                  (attr_q[ABT_BIT] == $past(wdata[ABT_BIT])));

  // R3: reads never show the update flag
  p_no_upd_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |-> !rdata[UPD_BIT]);

  // R4: other offsets read as zero
  p_other_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_hit |-> (rdata == '0));

endmodule

// File: rtl/gbp_decider.sv
module gbp_decider
  import gbp_pkg::*;
#(
  parameter int unsigned ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_id,
  input  logic            xlate_en,
  input  logic            abort_flag,
  output logic            dec_valid,
  output logic [1:0]      dec_code,
  output logic [ID_W-1:0] dec_id
);

  dec_e            verdict_d;
  dec_e            verdict_q;
  logic            valid_q;
  logic [ID_W-1:0] id_q;

  assign verdict_d = gbp_decide(xlate_en, abort_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      verdict_q <= DEC_XLATE;
      id_q      <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        verdict_q <= verdict_d;
        id_q      <= req_id;
      end
    end
  end

  assign dec_valid = valid_q;
  assign dec_code  = verdict_q;
  assign dec_id    = id_q;

  // R8: verdict appears exactly one cycle after the strobe, with its tag
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid && (dec_id == $past(req_id)));

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dec_valid);

  // R5: enable high always translates
  p_translate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && xlate_en |=> dec_code == 2'd0);

  // R6: enable low, abort clear bypasses
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !xlate_en && !abort_flag |=> dec_code == 2'd1);

  // R7: enable low, abort set aborts; code 3 never shows
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !xlate_en && abort_flag |=> dec_code == 2'd2);

  p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_code != 2'd3);

endmodule

// File: rtl/gbp_attr_ctl.sv
module gbp_attr_ctl
  import gbp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned ID_W    = 4,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h44,
  parameter int unsigned UPD_BIT = 31,
  parameter int unsigned ABT_BIT = 20,
  parameter logic [DATA_W-1:0] RST_VAL = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xlate_en,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  output logic              dec_valid,
  output logic [1:0]        dec_code,
  output logic [ID_W-1:0]   dec_id
);

  logic abort_flag;

  gbp_regfile #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .REG_OFS(REG_OFS),
    .UPD_BIT(UPD_BIT),
    .ABT_BIT(ABT_BIT),
    .RST_VAL(RST_VAL)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .abort_flag(abort_flag)
  );

  // Decider sees the pre-write abort flag in a collision cycle (R9).
  gbp_decider #(
    .ID_W(ID_W)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_id    (req_id),
    .xlate_en  (xlate_en),
    .abort_flag(abort_flag),
    .dec_valid (dec_valid),
    .dec_code  (dec_code),
    .dec_id    (dec_id)
  );

  // R9: a request colliding with an abort-bit change still uses the old bit
  p_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !xlate_en && reg_wr_en && (reg_addr == REG_OFS) &&
    reg_wdata[UPD_BIT] && (reg_wdata[ABT_BIT] != abort_flag)
    |=> dec_code == ($past(abort_flag) ? 2'd2 : 2'd1));

endmodule

// File: tb/gbp_attr_ctl_tb.sv
module gbp_attr_ctl_tb;

  localparam logic [7:0] OFS = 8'h44;
  localparam logic [1:0] C_XL = 2'd0, C_BP = 2'd1, C_AB = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xlate_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_id = '0;
  logic        dec_valid;
  logic [1:0]  dec_code;
  logic [3:0]  dec_id;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gbp_attr_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xlate_en(xlate_en),
    .req_valid(req_valid), .req_id(req_id), .dec_valid(dec_valid),
    .dec_code(dec_code), .dec_id(dec_id)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic check_read(input logic [7:0] a, input logic [31:0] exp,
                            input string rq);
    @(negedge clk);
    reg_addr = a;
    #2;
    chk(reg_rdata == exp, rq, reg_rdata, exp);
  endtask

  task automatic do_req(input bit en, input logic [3:0] id,
                        input logic [1:0] exp, input string rq);
    @(negedge clk);
    req_valid = 1'b1; xlate_en = en; req_id = id;
    @(negedge clk);
    req_valid = 1'b0; xlate_en = !en;    // R10: late change must not matter
    chk(dec_valid == 1'b1, "R8 valid", {31'd0, dec_valid}, 32'd1);
    chk(dec_id == id, "R8 tag", {28'd0, dec_id}, {28'd0, id});
    chk(dec_code == exp, rq, {30'd0, dec_code}, {30'd0, exp});
    @(negedge clk);
    chk(dec_valid == 1'b0, "R8 drop", {31'd0, dec_valid}, 32'd0);
  endtask

  task automatic t_reset;
    check_read(OFS, 32'h0000_1000, "R1 reset value");
    check_read(8'h40, 32'h0, "R4 other offset reads zero");
    chk(dec_valid == 1'b0, "R1 no verdict", {31'd0, dec_valid}, 32'd0);
  endtask

  task automatic t_basic;
    do_req(1'b0, 4'h1, C_BP, "R6 bypass at reset");
    do_req(1'b1, 4'h2, C_XL, "R5 translate");
  endtask

  task automatic t_gated;
    do_write(OFS, 32'h0010_0000);
    check_read(OFS, 32'h0000_1000, "R2 write without update ignored");
    do_req(1'b0, 4'h3, C_BP, "R2 still bypass");
    do_write(OFS, 32'h8010_0000);
    check_read(OFS, 32'h0010_0000, "R3 update stored, flag cleared");
    do_req(1'b0, 4'h4, C_AB, "R7 abort");
    do_req(1'b1, 4'h5, C_XL, "R5 translate despite abort bit");
    do_req(1'b0, 4'h6, C_AB, "R10 enable sampled at request");
  endtask

  task automatic t_other_offset;
    do_write(8'h40, 32'h8000_1000);
    check_read(OFS, 32'h0010_0000, "R4 write elsewhere ignored");
    check_read(8'h48, 32'h0, "R4 other offset zero");
    do_write(OFS, 32'h8000_1000);
    check_read(OFS, 32'h0000_1000, "R3 restore");
    do_req(1'b0, 4'h7, C_BP, "R6 bypass after clear");
  endtask

  task automatic t_collision;
    // set abort in same cycle as request: old (clear) value decides
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = OFS; reg_wdata = 32'h8010_0000;
    req_valid = 1'b1; xlate_en = 1'b0; req_id = 4'h8;
    @(negedge clk);
    reg_wr_en = 1'b0; req_valid = 1'b0;
    chk(dec_code == C_BP, "R9 collision uses old value", {30'd0, dec_code}, 32'd1);
    do_req(1'b0, 4'h9, C_AB, "R9 next request sees new value");
    // clear abort in same cycle: old (set) value decides
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = OFS; reg_wdata = 32'h8000_0000;
    req_valid = 1'b1; xlate_en = 1'b0; req_id = 4'hA;
    @(negedge clk);
    reg_wr_en = 1'b0; req_valid = 1'b0;
    chk(dec_code == C_AB, "R9 collision keeps abort", {30'd0, dec_code}, 32'd2);
    do_req(1'b0, 4'hB, C_BP, "R9 bypass after clear");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1'b1; xlate_en = 1'b1; req_id = 4'hC;
    @(negedge clk);
    chk(dec_id == 4'hC && dec_code == C_XL, "R8 first of pair",
        {26'd0, dec_code, dec_id}, {26'd0, C_XL, 4'hC});
    xlate_en = 1'b0; req_id = 4'hD;
    @(negedge clk);
    req_valid = 1'b0;
    chk(dec_valid && dec_id == 4'hD && dec_code == C_BP, "R8 second of pair",
        {26'd0, dec_code, dec_id}, {26'd0, C_BP, 4'hD});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_gated();
    t_other_offset();
    t_collision();
    t_back_to_back();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule